// File: doc/BRIEF.md
# I2C Controller Event Vector Unit

This block gathers the event flags of an I2C controller and turns them into one interrupt line and one numeric code. The bus engine gives a one-cycle set pulse for each of its seven events. Each pulse latches a sticky status flag. An enable mask decides which of those flags may raise the interrupt. Software can inspect the flags directly, and it can clear any of them by writing ones.

The usual service path is faster. Software reads the vector register and gets the code of the most urgent pending event that is enabled. That same read retires the flag it reported. An interrupt handler can therefore loop on vector reads until it reads zero, instead of scanning and clearing a bitmask. The status register also shows two level signals from the bus engine: a receive-shift-full indication and a bus-busy indication.

Top module: `i2c_evt_vector`

## Requirements
- R1: Reset clears all seven event flags and all mask bits. While reset is applied and just after it, the interrupt output is low and the vector register reads 0.
- R2: A pulse on evt_set[i] sets status bit i. The status layout is arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2, receive ready at bit 3, transmit ready at bit 4, stop detected at bit 5 and addressed-as-slave at bit 6. A flag stays set until it is cleared.
- R3: Status bit 11 shows the rx_shift_full input and status bit 12 shows the bus_busy input. Status bits 7 to 10 and 13 to 15 read 0.
- R4: A write to the status register at offset 0x08 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: The mask register at offset 0x04 holds bits 0 to 6, with the same event order as the status register. Writes to bits 7 to 15 are dropped, and those bits read 0.
- R6: The vector register at offset 0x28 returns the code of the lowest-numbered flag that is both set and enabled. The codes are arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6 and addressed-as-slave 7.
- R7: The vector register reads 0 when no enabled flag is set. A flag that is set but masked still shows in the status register.
- R8: The irq output is high exactly when at least one flag is set together with its mask bit.
- R9: A read strobe at the vector offset clears only the flag whose code was returned, at the end of that cycle. A vector read that returns 0 clears nothing.
- R10: When a set pulse and a clear (by status write or by vector read) hit the same flag in the same cycle, the flag ends up set.
- R11: Writes to the vector offset change neither the flags nor the mask. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_rd | input | 1 | Read strobe; at the vector offset it retires the reported event |
| reg_rdata | output | DATA_W (16) | Read data for reg_addr, combinational |
| evt_set | input | N_EVT (7) | One-cycle set pulses, one per event |
| rx_shift_full | input | 1 | Receive-shift-full level from the bus engine |
| bus_busy | input | 1 | Bus-busy level from the bus engine |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the same flag in one cycle: a new set pulse from the bus engine, and a clear from software. The clear comes either from a write-one to the status register or from the acknowledge that a vector read performs. The bench provokes both collisions by driving the set pulse in the same cycle as the status write, and then again in the same cycle as the vector read strobe. It then reads the status register on the next cycle and expects the flag to still be set. In the vector-read case it also expects the returned code to be the code of the flag that was pending before the collision.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   localparam int unsigned EVT_COUNT = 7;

   // bit index of each event inside the status and mask registers
   typedef enum int unsigned {
      EV_ARB_LOST  = 0,
      EV_NO_ACK    = 1,
      EV_ACC_READY = 2,
      EV_RX_READY  = 3,
      EV_TX_READY  = 4,
      EV_STOP_SEEN = 5,
      EV_AS_TARGET = 6
   } evt_idx_e;

   localparam int unsigned OFS_MASK   = 'h04;
   localparam int unsigned OFS_STATUS = 'h08;
   localparam int unsigned OFS_VECTOR = 'h28;
   localparam int unsigned BIT_RSFULL = 11;
   localparam int unsigned BIT_BUSY   = 12;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
   parameter int unsigned N_EVT  = 7,
   parameter int unsigned CODE_W = 3
) (
   input  logic [N_EVT-1:0]  pend,
   output logic [N_EVT-1:0]  grant,
   output logic [CODE_W-1:0] code
);
   // prefix OR: blocked[i] is set when any lower index is pending
   logic [N_EVT:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N_EVT; i++) begin : g_chain
      assign blocked[i+1] = blocked[i] | pend[i];
      assign grant[i]     = pend[i] & ~blocked[i];
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < N_EVT; i++) begin
         if (grant[i]) code = code | CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
   parameter int unsigned N_EVT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] set_pulse,
   input  logic [N_EVT-1:0] w1c,
   input  logic [N_EVT-1:0] ack_clr,
   output logic [N_EVT-1:0] flags
);
   for (genvar i = 0; i < N_EVT; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                   flags[i] <= 1'b0;
         else if (set_pulse[i])        flags[i] <= 1'b1;
         else if (w1c[i] | ack_clr[i]) flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned N_EVT      = 7,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned MASK_OFS   = 'h04,
   parameter int unsigned STAT_OFS   = 'h08,
   parameter int unsigned VEC_OFS    = 'h28,
   parameter int unsigned RSF_BIT    = 11,
   parameter int unsigned BUSY_BIT   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic [N_EVT-1:0]  flags,
   input  logic [CODE_W-1:0] code,
   input  logic              rsf_lvl,
   input  logic              busy_lvl,
   output logic [N_EVT-1:0]  mask_q,
   output logic [N_EVT-1:0]  w1c,
   output logic              vec_ack,
   output logic [DATA_W-1:0] rdata
);
   logic hit_mask, hit_stat, hit_vec;
   assign hit_mask = (addr == ADDR_W'(MASK_OFS));
   assign hit_stat = (addr == ADDR_W'(STAT_OFS));
   assign hit_vec  = (addr == ADDR_W'(VEC_OFS));

   always_ff @(posedge clk) begin
      if (!rst_n)                mask_q <= '0;
      else if (we && hit_mask)   mask_q <= wdata[N_EVT-1:0];
   end

   assign w1c     = (we && hit_stat) ? wdata[N_EVT-1:0] : '0;
   assign vec_ack = rd && hit_vec;

   always_comb begin
      rdata = '0;
      if (hit_mask) begin
         rdata[N_EVT-1:0] = mask_q;
      end else if (hit_stat) begin
         rdata[N_EVT-1:0] = flags;
         rdata[RSF_BIT]   = rsf_lvl;
         rdata[BUSY_BIT]  = busy_lvl;
      end else if (hit_vec) begin
         rdata[CODE_W-1:0] = code;
      end
   end
endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned N_EVT    = i2c_evt_pkg::EVT_COUNT,
   parameter int unsigned MASK_OFS = i2c_evt_pkg::OFS_MASK,
   parameter int unsigned STAT_OFS = i2c_evt_pkg::OFS_STATUS,
   parameter int unsigned VEC_OFS  = i2c_evt_pkg::OFS_VECTOR,
   parameter int unsigned RSF_BIT  = i2c_evt_pkg::BIT_RSFULL,
   parameter int unsigned BUSY_BIT = i2c_evt_pkg::BIT_BUSY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_EVT-1:0]  evt_set,
   input  logic              rx_shift_full,
   input  logic              bus_busy,
   output logic              irq
);
   localparam int unsigned CODE_W = $clog2(N_EVT + 1);

   // elaboration-time parameter checks
   if (N_EVT < 1 || N_EVT > DATA_W) begin : g_bad_nevt
      $error("N_EVT must be between 1 and DATA_W");
   end
   if (RSF_BIT >= DATA_W || BUSY_BIT >= DATA_W || RSF_BIT < N_EVT ||
       BUSY_BIT < N_EVT || RSF_BIT == BUSY_BIT) begin : g_bad_lvl
      $error("level status bits must be distinct, above the flags and inside DATA_W");
   end
   if (CODE_W > DATA_W) begin : g_bad_code
      $error("vector code does not fit the data width");
   end
   if (MASK_OFS == STAT_OFS || MASK_OFS == VEC_OFS || STAT_OFS == VEC_OFS ||
       VEC_OFS >= (1 << ADDR_W) || STAT_OFS >= (1 << ADDR_W) ||
       MASK_OFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("register offsets must be distinct and fit ADDR_W");
   end

   logic [N_EVT-1:0]  flags_q;
   logic [N_EVT-1:0]  mask_q;
   logic [N_EVT-1:0]  w1c;
   logic [N_EVT-1:0]  grant;
   logic [N_EVT-1:0]  ack_clr;
   logic [CODE_W-1:0] vec_code;
   logic              vec_ack;
   logic [N_EVT-1:0]  pend_en;

   assign pend_en = flags_q & mask_q;
   assign ack_clr = vec_ack ? grant : '0;
   assign irq     = |pend_en;

   evt_prio_enc #(
      .N_EVT  (N_EVT),
      .CODE_W (CODE_W)
   ) u_enc (
      .pend  (pend_en),
      .grant (grant),
      .code  (vec_code)
   );

   evt_status_bank #(
      .N_EVT (N_EVT)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (evt_set),
      .w1c       (w1c),
      .ack_clr   (ack_clr),
      .flags     (flags_q)
   );

   evt_reg_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .N_EVT    (N_EVT),
      .CODE_W   (CODE_W),
      .MASK_OFS (MASK_OFS),
      .STAT_OFS (STAT_OFS),
      .VEC_OFS  (VEC_OFS),
      .RSF_BIT  (RSF_BIT),
      .BUSY_BIT (BUSY_BIT)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (reg_addr),
      .we       (reg_we),
      .wdata    (reg_wdata),
      .rd       (reg_rd),
      .flags    (flags_q),
      .code     (vec_code),
      .rsf_lvl  (rx_shift_full),
      .busy_lvl (bus_busy),
      .mask_q   (mask_q),
      .w1c      (w1c),
      .vec_ack  (vec_ack),
      .rdata    (reg_rdata)
   );
endmodule

// File: rtl/evt_vector_chk.sv
module evt_vector_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned N_EVT    = 7,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned MASK_OFS = 'h04,
   parameter int unsigned STAT_OFS = 'h08,
   parameter int unsigned VEC_OFS  = 'h28
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_rd,
   input logic [N_EVT-1:0]  evt_set,
   input logic [N_EVT-1:0]  flags,
   input logic [N_EVT-1:0]  mask,
   input logic [N_EVT-1:0]  grant,
   input logic [CODE_W-1:0] code,
   input logic              irq
);
   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flags == '0 && mask == '0));

   // R2
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(evt_set)) == $past(evt_set)));

   // R4
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(STAT_OFS)) |=>
      ((flags & $past(reg_wdata[N_EVT-1:0]) & ~$past(evt_set)) == '0));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == ADDR_W'(MASK_OFS)) |=> $stable(mask));

   // R6
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (code != '0));

   // R9
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(VEC_OFS)) |=>
      ((flags & $past(grant) & ~$past(evt_set)) == '0));
endmodule

bind i2c_evt_vector evt_vector_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .N_EVT    (N_EVT),
   .CODE_W   (CODE_W),
   .MASK_OFS (MASK_OFS),
   .STAT_OFS (STAT_OFS),
   .VEC_OFS  (VEC_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rd    (reg_rd),
   .evt_set   (evt_set),
   .flags     (flags_q),
   .mask      (mask_q),
   .grant     (grant),
   .code      (vec_code),
   .irq       (irq)
);

// File: tb/i2c_evt_vector_bench.sv
module i2c_evt_vector_bench;
   localparam logic [7:0] A_MASK = 8'h04;
   localparam logic [7:0] A_STAT = 8'h08;
   localparam logic [7:0] A_VEC  = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic [6:0]  evt_set = '0;
   logic        rx_shift_full = 1'b0;
   logic        bus_busy = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   i2c_evt_vector u_i2c_evt_vector (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .evt_set(evt_set), .rx_shift_full(rx_shift_full),
      .bus_busy(bus_busy), .irq(irq)
   );

   // entry: {set pattern[16:10], mask[9:3], expected vector[2:0]}
   localparam int NV = 10;
   localparam logic [16:0] TBL [NV] = '{
      {7'h00, 7'h7F, 3'd0},
      {7'h01, 7'h7F, 3'd1},
      {7'h40, 7'h7F, 3'd7},
      {7'h7F, 7'h7F, 3'd1},
      {7'h7F, 7'h7E, 3'd2},
      {7'h30, 7'h7F, 3'd5},
      {7'h30, 7'h0F, 3'd0},
      {7'h0C, 7'h08, 3'd4},
      {7'h44, 7'h40, 3'd7},
      {7'h06, 7'h7F, 3'd2}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b0;
      #1 d = reg_rdata;
   endtask

   task automatic rd_vec(output logic [15:0] d);
      @(negedge clk);
      reg_addr = A_VEC; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk);
      evt_set = m;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      peek(A_STAT, d); chk("R1 status in reset", d, 16'h0000);
      chk("R1 irq in reset", {15'b0, irq}, 16'h0000);
      rst_n = 1'b1;
      peek(A_MASK, d); chk("R1 mask after reset", d, 16'h0000);
      peek(A_VEC, d);  chk("R1 vector after reset", d, 16'h0000);
      chk("R1 irq after reset", {15'b0, irq}, 16'h0000);

      // table walk: R2 R6 R7 R8
      for (int k = 0; k < NV; k++) begin
         logic [6:0] s, m;
         logic [2:0] v;
         s = TBL[k][16:10]; m = TBL[k][9:3]; v = TBL[k][2:0];
         wr(A_STAT, 16'h007F);
         wr(A_MASK, {9'b0, m});
         pulse(s);
         peek(A_STAT, d); chk("R2 status latch", d, {9'b0, s});
         peek(A_VEC, d);  chk("R6 R7 vector code", d, {13'b0, v});
         chk("R8 irq level", {15'b0, irq}, {15'b0, (v != 3'd0)});
      end

      // R3 level bits
      wr(A_STAT, 16'h007F);
      rx_shift_full = 1'b1;
      peek(A_STAT, d); chk("R3 rx shift full bit", d, 16'h0800);
      bus_busy = 1'b1; rx_shift_full = 1'b0;
      peek(A_STAT, d); chk("R3 bus busy bit", d, 16'h1000);
      bus_busy = 1'b0;

      // R4 write one to clear
      pulse(7'h7F);
      wr(A_STAT, 16'h0005);
      peek(A_STAT, d); chk("R4 w1c partial", d, 16'h007A);

      // R5 mask width
      wr(A_MASK, 16'hFFFF);
      peek(A_MASK, d); chk("R5 mask upper bits", d, 16'h007F);

      // R9 clear on read, flags 0x7A
      rd_vec(d); chk("R9 first vector", d, 16'h0002);
      peek(A_STAT, d); chk("R9 only reported cleared", d, 16'h0078);
      rd_vec(d); chk("R9 second vector", d, 16'h0004);
      peek(A_STAT, d); chk("R9 status after second", d, 16'h0070);
      wr(A_MASK, 16'h0040);
      rd_vec(d); chk("R9 masked priority", d, 16'h0007);
      peek(A_STAT, d); chk("R9 status after masked read", d, 16'h0030);
      wr(A_MASK, 16'h0000);
      rd_vec(d); chk("R9 zero vector", d, 16'h0000);
      peek(A_STAT, d); chk("R9 zero read clears nothing", d, 16'h0030);

      // R10 set vs w1c in one cycle
      wr(A_STAT, 16'h007F);
      @(negedge clk);
      evt_set = 7'h08; reg_addr = A_STAT; reg_wdata = 16'h0008; reg_we = 1'b1;
      @(negedge clk);
      evt_set = '0; reg_we = 1'b0;
      peek(A_STAT, d); chk("R10 set beats w1c", d, 16'h0008);

      // R10 set vs vector acknowledge in one cycle
      wr(A_STAT, 16'h007F);
      wr(A_MASK, 16'h007F);
      pulse(7'h01);
      @(negedge clk);
      reg_addr = A_VEC; reg_rd = 1'b1; evt_set = 7'h01;
      #1 d = reg_rdata; chk("R10 vector during collision", d, 16'h0001);
      @(negedge clk);
      reg_rd = 1'b0; evt_set = '0;
      peek(A_STAT, d); chk("R10 set beats acknowledge", d, 16'h0001);

      // R11 write to vector ignored, unmapped read zero
      wr(A_VEC, 16'hFFFF);
      peek(A_STAT, d); chk("R11 vector write keeps flags", d, 16'h0001);
      peek(A_MASK, d); chk("R11 vector write keeps mask", d, 16'h007F);
      peek(8'h10, d);  chk("R11 unmapped read", d, 16'h0000);

      // R1 reset mid-run
      pulse(7'h22);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      peek(A_STAT, d); chk("R1 flags cleared by reset", d, 16'h0000);
      peek(A_MASK, d); chk("R1 mask cleared by reset", d, 16'h0000);
      chk("R1 irq after mid-run reset", {15'b0, irq}, 16'h0000);

      summary();
   end
endmodule